// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This unit sits beside one DMA channel and decides when completed descriptors should interrupt the processor. It raises an interrupt in two cases. The first is when a programmed number of completions has built up. The second is when a programmed quiet period passes after the last completion without the count reaching its threshold. This keeps the interrupt rate low under heavy traffic and still bounds the latency of the last few transfers.

A modulo counter is loaded from the threshold field. Each completion pulse decrements it, and a threshold-pending flag is set when the count is used up. A small two-state timer (`TMR_IDLE`, `TMR_RUN`) is reloaded from the delay field on every completion. It counts down on a prescaled tick. When it expires it sets a delay-pending flag and rewinds the completion counter.

The transitions are:
- `TMR_IDLE`→`TMR_RUN`: a completion arrives while the delay field is nonzero.
- `TMR_RUN`→`TMR_RUN` with reload: another completion arrives.
- `TMR_RUN`→`TMR_IDLE` on expiry: a tick arrives at value 1.
- `TMR_RUN`→`TMR_IDLE` on disable: the delay field becomes zero.

Both flags are cleared by write-one strobes. They are combined with an externally held error flag and an enable mask into one level interrupt. The live count and live timer value are brought out for readback.

Top module: `coal_irq_unit`

## Requirements
- R1: After reset, both pending flags, the count, the timer value and the interrupt are all 0.
- R2: A `start_i` pulse loads the count from `thresh_i`, visible one cycle later.
- R3: A completion with count above 1 decrements the count. A completion with count 0 or 1 sets the threshold-pending flag and reloads the count from `thresh_i`, so a threshold of 0 acts as 1.
- R4: A completion while `delay_i` is nonzero loads the timer with `delay_i` (state `TMR_RUN`). A later completion reloads it, whatever value it had reached.
- R5: In `TMR_RUN` each `tick_i` pulse lowers the timer by one. A tick at value 1 brings the timer to 0 and enters `TMR_IDLE`. It also sets the delay-pending flag and reloads the count from `thresh_i`. After that the timer stays at 0 and fires no more, whatever ticks arrive.
- R6: While `delay_i` is 0 the timer is held at 0 in `TMR_IDLE` and no delay-pending flag is produced.
- R7: `clr_i[0]` clears the threshold-pending flag and `clr_i[1]` clears the delay-pending flag. A set in the same cycle wins over a clear.
- R8: `irq_o` is high exactly when `(ioc & irq_en_i[0]) | (dly & irq_en_i[1]) | (err_i & irq_en_i[2])`.
- R9: `start_i` wins over a completion in the same cycle: the count is reloaded and no threshold flag is set. A completion wins over an expiring tick in the same cycle: the timer is reloaded and no delay flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_i | input | 1 | One-cycle descriptor-completion pulse |
| start_i | input | 1 | One-cycle channel start pulse, reloads the count |
| tick_i | input | 1 | Prescaled timer tick enable |
| thresh_i | input | 8 | Completion threshold field |
| delay_i | input | 8 | Delay count field, 0 disables the timer |
| irq_en_i | input | 3 | Enable mask: bit0 threshold, bit1 delay, bit2 error |
| clr_i | input | 2 | Write-one-to-clear strobes: bit0 threshold, bit1 delay |
| err_i | input | 1 | Error-pending flag, passed through to the interrupt |
| ioc_pend_o | output | 1 | Threshold-pending flag |
| dly_pend_o | output | 1 | Delay-pending flag |
| cnt_o | output | 8 | Live completion count |
| tmr_o | output | 8 | Live timer value |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situations to reach are the same-cycle collisions. These are a completion landing exactly on the tick that would expire the timer, and a start colliding with the completion that would exhaust the count. Each depends on lining up two pulses on one edge. The bench walks the timer down tick by tick, at tick spacings of one to three cycles, so it knows when the value sits at 1. It then issues the completion and the final tick together. It also sweeps all eight flag combinations against all eight enable masks, building each flag combination through the normal completion and timer paths.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    localparam int SRC_IOC = 0;
    localparam int SRC_DLY = 1;
    localparam int SRC_ERR = 2;
    localparam int NSRC    = 3;
endpackage

// File: rtl/coal_cmpl_counter.sv
module coal_cmpl_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmpl,
    input  logic             start,
    input  logic             expire,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] cnt,
    output logic             ioc_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign ioc_evt = cmpl && !start && (cnt <= ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= thresh;
        end else if (cmpl) begin
            if (cnt <= ONE) cnt <= thresh;
            else            cnt <= cnt - ONE;
        end else if (expire) begin
            cnt <= thresh;
        end
    end

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cnt == $past(thresh)); // R2
    AST_IOC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ioc_evt |=> cnt == $past(thresh)); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl && !start && cnt > ONE) |=> cnt == $past(cnt) - ONE); // R3
endmodule

// File: rtl/coal_delay_timer.sv
module coal_delay_timer
    import coal_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmpl,
    input  logic             tick,
    input  logic [TMR_W-1:0] delay,
    output logic [TMR_W-1:0] tmr,
    output logic             expire
);
    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    tmr_state_e       state_q, state_n;
    logic [TMR_W-1:0] tmr_n;

    always_comb begin
        state_n = state_q;
        tmr_n   = tmr;
        expire  = 1'b0;
        unique case (state_q)
            TMR_IDLE: begin
                tmr_n = '0;
                if (cmpl && delay != '0) begin
                    state_n = TMR_RUN;
                    tmr_n   = delay;
                end
            end
            TMR_RUN: begin
                if (delay == '0) begin
                    state_n = TMR_IDLE;
                    tmr_n   = '0;
                end else if (cmpl) begin
                    tmr_n = delay;
                end else if (tick) begin
                    if (tmr == ONE) begin
                        expire  = 1'b1;
                        state_n = TMR_IDLE;
                        tmr_n   = '0;
                    end else begin
                        tmr_n = tmr - ONE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            tmr     <= '0;
        end else begin
            state_q <= state_n;
            tmr     <= tmr_n;
        end
    end

    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN) |-> tmr != '0); // R5
    AST_EXPIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (tmr == '0 && state_q == TMR_IDLE)); // R5
    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (delay == '0) |=> tmr == '0); // R6
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl && delay != '0) |=> tmr == $past(delay)); // R4
endmodule

// File: rtl/coal_pending_flags.sv
module coal_pending_flags #(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    output logic [NFLAG-1:0] pend
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) pend[i] <= 1'b0;
            else        pend[i] <= set[i] | (pend[i] & ~clr[i]);
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> pend[i]); // R7
        AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !pend[i]); // R7
    end
endmodule

// File: rtl/coal_irq_unit.sv
module coal_irq_unit
    import coal_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmpl_i,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic [TMR_W-1:0] delay_i,
    input  logic [2:0]       irq_en_i,
    input  logic [1:0]       clr_i,
    input  logic             err_i,
    output logic             ioc_pend_o,
    output logic             dly_pend_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [TMR_W-1:0] tmr_o,
    output logic             irq_o
);
    logic            expire;
    logic            ioc_evt;
    logic [1:0]      pend;
    logic [NSRC-1:0] src;

    coal_delay_timer #(.TMR_W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .cmpl(cmpl_i), .tick(tick_i),
        .delay(delay_i), .tmr(tmr_o), .expire(expire)
    );

    coal_cmpl_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .cmpl(cmpl_i), .start(start_i),
        .expire(expire), .thresh(thresh_i), .cnt(cnt_o), .ioc_evt(ioc_evt)
    );

    coal_pending_flags #(.NFLAG(2)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set({expire, ioc_evt}), .clr(clr_i), .pend(pend)
    );

    assign ioc_pend_o = pend[SRC_IOC];
    assign dly_pend_o = pend[SRC_DLY];
    assign src        = {err_i, pend[SRC_DLY], pend[SRC_IOC]};
    assign irq_o      = |(src & irq_en_i);

    AST_DLY_FROM_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dly_pend_o) |-> $past(tmr_o) == TMR_W'(1)); // R5
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_en_i != 3'b000)); // R8
endmodule

// File: tb/tb_coal_irq_unit.sv
module tb_coal_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmpl_i = 1'b0, start_i = 1'b0, tick_i = 1'b0, err_i = 1'b0;
    logic [7:0] thresh_i = '0, delay_i = '0;
    logic [2:0] irq_en_i = '0;
    logic [1:0] clr_i = '0;
    logic       ioc_pend_o, dly_pend_o, irq_o;
    logic [7:0] cnt_o, tmr_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    coal_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .cmpl_i(cmpl_i), .start_i(start_i),
        .tick_i(tick_i), .thresh_i(thresh_i), .delay_i(delay_i),
        .irq_en_i(irq_en_i), .clr_i(clr_i), .err_i(err_i),
        .ioc_pend_o(ioc_pend_o), .dly_pend_o(dly_pend_o),
        .cnt_o(cnt_o), .tmr_o(tmr_o), .irq_o(irq_o)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_cmpl();
        cmpl_i = 1'b1; step(); cmpl_i = 1'b0;
    endtask

    task automatic do_start();
        start_i = 1'b1; step(); start_i = 1'b0;
    endtask

    task automatic do_tick(input int period);
        tick_i = 1'b1; step(); tick_i = 1'b0;
        for (int i = 1; i < period; i++) step();
    endtask

    task automatic clear_all();
        clr_i = 2'b11; step(); clr_i = 2'b00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int mc, thr, fires;
        repeat (3) step();
        // R1 reset state
        chk("R1 ioc", ioc_pend_o, 0); chk("R1 dly", dly_pend_o, 0);
        chk("R1 cnt", cnt_o, 0);      chk("R1 tmr", tmr_o, 0);
        irq_en_i = 3'b111;
        chk("R1 irq", irq_o, 0);
        rst_n = 1'b1; step();

        // R2 / R3 threshold sweep with delay timer off
        delay_i = 8'd0;
        for (int t = 0; t <= 6; t++) begin
            thr = t;
            thresh_i = 8'(t);
            do_start();
            chk("R2 start load", cnt_o, t);
            mc = t;
            fires = 0;
            for (int n = 0; n < 2 * (t < 1 ? 1 : t); n++) begin
                do_cmpl();
                if (mc <= 1) begin mc = thr; fires = 1; end
                else begin mc = mc - 1; fires = 0; end
                chk("R3 count", cnt_o, mc);
                chk("R3 ioc", ioc_pend_o, fires);
                chk("R6 no timer", tmr_o, 0);
                if (fires != 0) clear_all();
            end
        end

        // R4 / R5 timer sweep over delay values and tick spacing
        thresh_i = 8'd50;
        do_start();
        for (int d = 1; d <= 6; d++) begin
            for (int p = 1; p <= 3; p++) begin
                clear_all();
                delay_i = 8'(d);
                do_cmpl();
                chk("R4 load", tmr_o, d);
                for (int k = 1; k <= d; k++) begin
                    do_tick(p);
                    chk("R5 value", tmr_o, d - k);
                    chk("R5 dly", dly_pend_o, (k == d) ? 1 : 0);
                end
                chk("R5 reload count", cnt_o, 50);
                clear_all();
                do_tick(1); do_tick(1);
                chk("R5 fires once", dly_pend_o, 0);
                chk("R5 stays zero", tmr_o, 0);
            end
        end

        // R4 restart in mid-count
        delay_i = 8'd5;
        do_cmpl(); do_tick(1); do_tick(1); do_tick(1);
        chk("R4 mid", tmr_o, 2);
        do_cmpl();
        chk("R4 restart", tmr_o, 5);

        // R6 delay field of zero stops the timer
        delay_i = 8'd0; step();
        chk("R6 stopped", tmr_o, 0);
        for (int i = 0; i < 8; i++) do_tick(1);
        chk("R6 no dly", dly_pend_o, 0);

        // R9 completion wins over expiring tick
        delay_i = 8'd3;
        do_cmpl(); do_tick(1); do_tick(1);
        chk("R9 at one", tmr_o, 1);
        cmpl_i = 1'b1; tick_i = 1'b1; step(); cmpl_i = 1'b0; tick_i = 1'b0;
        chk("R9 reloaded", tmr_o, 3);
        chk("R9 no dly", dly_pend_o, 0);
        delay_i = 8'd0; step();

        // R9 start wins over completion
        thresh_i = 8'd1; do_start(); clear_all();
        thresh_i = 8'd4;
        cmpl_i = 1'b1; start_i = 1'b1; step(); cmpl_i = 1'b0; start_i = 1'b0;
        chk("R9 start cnt", cnt_o, 4);
        chk("R9 start no ioc", ioc_pend_o, 0);

        // R7 set wins over clear; clear works alone
        thresh_i = 8'd1; do_start();
        clr_i = 2'b01; cmpl_i = 1'b1; step(); clr_i = 2'b00; cmpl_i = 1'b0;
        chk("R7 set wins", ioc_pend_o, 1);
        clr_i = 2'b01; step(); clr_i = 2'b00;
        chk("R7 clear", ioc_pend_o, 0);

        // R8 all flag combinations against all enable masks
        for (int f = 0; f < 8; f++) begin
            clear_all();
            thresh_i = 8'd1;
            if (f[1]) begin
                delay_i = 8'd1; do_cmpl(); do_tick(1);
                delay_i = 8'd0; clr_i = 2'b01; step(); clr_i = 2'b00;
            end
            if (f[0]) do_cmpl();
            err_i = f[2];
            step();
            chk("R8 flags", {err_i, dly_pend_o, ioc_pend_o}, f);
            for (int e = 0; e < 8; e++) begin
                irq_en_i = 3'(e);
                #1;
                chk("R8 irq", irq_o, ((f & e) != 0) ? 1 : 0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule